// File: doc/BRIEF.md
# DRAM Bank Power-State Controller

This block governs the power state of a single DRAM bank. A requester raises a request and holds it until the controller grants it. Grants are only given while the bank is fully awake. Each grant adds one to an in-flight count, and each completion pulse removes one. While nothing is in flight and no request is pending, an idle counter runs. When that counter reaches a programmable limit, the bank is sent to a low-power state. Configuration picks which one: standby, nap or powerdown.

A limit of zero means the bank sleeps on the first cycle after its last in-flight access drains. Entering a low-power state takes a fixed number of cycles. A request that arrives during that entry is held until the entry is complete. A request that finds the bank asleep starts a wake-up. The wake-up lasts longer the deeper the state. Throughout all of this the request simply sees ready held low.

Top module: `bank_pwr_ctrl`

## Requirements
- R1: After synchronous reset the bank reports active (`bank_state` 0), `req_ready` is high, `transit` is low and `inflight` is 0.
- R2: `req_ready` is high only when the bank is active, not in transit, and `inflight` is below `MAX_OUT`. A grant is a cycle with both `req_valid` and `req_ready` high.
- R3: `inflight` rises by one on each grant and falls by one on each `cpl_valid`. A grant and a completion in the same cycle leave it unchanged. A completion while it is 0 is ignored.
- R4: With `idle_limit` = N > 0, the bank leaves active on the clock edge that ends the (N+1)-th consecutive idle cycle. An idle cycle is one with the bank active, `inflight` 0 and `req_valid` low. The bank never leaves active while `inflight` is nonzero.
- R5: With `idle_limit` = 0, the bank leaves active on the edge that ends the first cycle in which `inflight` is 0 and no request is present.
- R6: Any cycle with `req_valid` high, or with `inflight` nonzero, restarts the idle count from zero.
- R7: `sleep_sel` is sampled when the idle limit is reached. Its values map to states as follows: 1 gives standby (`bank_state` 1), 2 gives nap (2), 3 gives powerdown (3), and 0 gives standby. `bank_state` holds that value until the bank is active again.
- R8: Entry into a low-power state lasts `ENTER_LAT` cycles. During entry `transit` is high and `bank_state` already shows the target state. After entry `transit` is low.
- R9: A request that finds the bank settled in a low-power state sees `req_ready` rise D+1 cycles later. D is `WAKE_SB`, `WAKE_NP` or `WAKE_PD` according to the state. `transit` is high during the wake-up.
- R10: A request raised during entry is held with `req_ready` low. Entry finishes first, then a full wake-up follows. From the first entry cycle, ready rises after `ENTER_LAT` + D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, held until granted |
| req_ready | output | 1 | Bank can accept the request this cycle |
| cpl_valid | input | 1 | One in-flight access completed |
| idle_limit | input | THR_W | Idle cycles tolerated before sleeping (0 = sleep on drain) |
| sleep_sel | input | 2 | Target low-power state: 1 standby, 2 nap, 3 powerdown, 0 standby |
| bank_state | output | 2 | 0 active, 1 standby, 2 nap, 3 powerdown |
| transit | output | 1 | Bank is entering or leaving a low-power state |
| inflight | output | $clog2(MAX_OUT+1) | Accesses granted but not yet completed |

## Verification
The bench targets the off-by-one edges of the idle count. A controller that counted one cycle short or long would sleep a cycle early or late, and the measured cycles-to-sleep would show it, with both a nonzero limit and a zero limit. It measures wake latency separately for each of the three depths. It also raises a request in the middle of entry: a controller that skipped the rest of entry, or dropped the held request, would show ready at the wrong cycle or never. It saturates the in-flight count and completes at zero, where a wrong counter would overflow, underflow or grant past the limit.

// File: rtl/bank_pwr_pkg.sv
package bank_pwr_pkg;
  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_ENTER  = 2'd1,
    PH_SLEEP  = 2'd2,
    PH_WAKE   = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_STANDBY = 2'd1,
    ST_NAP     = 2'd2,
    ST_PDOWN   = 2'd3
  } pstate_t;
endpackage

// File: rtl/bank_inflight_ctr.sv
module bank_inflight_ctr #(
  parameter int MAX_OUT = 4,
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          cpl,
  output logic [CW-1:0] cnt,
  output logic          zero,
  output logic          full
);
  logic [CW-1:0] cnt_q;
  logic          dec;

  // a completion with nothing outstanding is dropped
  assign dec = cpl && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);
  assign full = (cnt_q == CW'(MAX_OUT));
endmodule

// File: rtl/bank_idle_timer.sv
module bank_idle_timer #(
  parameter int THR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             drained,
  input  logic             req,
  input  logic [THR_W-1:0] limit,
  output logic             expire
);
  localparam logic [THR_W-1:0] SAT = {THR_W{1'b1}};

  logic [THR_W-1:0] idle_q;
  logic             quiet;

  assign quiet = active && drained && !req;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= '0;
    end else if (quiet) begin
      if (idle_q != SAT) idle_q <= idle_q + 1'b1;
    end else begin
      idle_q <= '0;
    end
  end

  assign expire = quiet && (idle_q >= limit);
endmodule

// File: rtl/bank_pwr_fsm.sv
module bank_pwr_fsm #(
  parameter int ENTER_LAT = 2,
  parameter int WAKE_SB   = 2,
  parameter int WAKE_NP   = 10,
  parameter int WAKE_PD   = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       expire,
  input  logic [1:0] sleep_sel,
  output logic       is_active,
  output logic       transit,
  output logic [1:0] bank_state
);
  import bank_pwr_pkg::*;

  localparam int M1   = (WAKE_PD > WAKE_NP) ? WAKE_PD : WAKE_NP;
  localparam int M2   = (WAKE_SB > ENTER_LAT) ? WAKE_SB : ENTER_LAT;
  localparam int MAXD = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXD + 1);

  phase_t        ph_q;
  pstate_t       lp_q;
  pstate_t       sel_st;
  logic [TW-1:0] tmr_q;
  logic [TW-1:0] wake_m1;
  logic          pend_q;

  assign sel_st = (sleep_sel == 2'd0) ? ST_STANDBY : pstate_t'(sleep_sel);

  always_comb begin
    case (lp_q)
      ST_NAP:   wake_m1 = TW'(WAKE_NP - 1);
      ST_PDOWN: wake_m1 = TW'(WAKE_PD - 1);
      default:  wake_m1 = TW'(WAKE_SB - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_ACTIVE;
      lp_q   <= ST_STANDBY;
      tmr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_ACTIVE: begin
          if (expire) begin
            ph_q  <= PH_ENTER;
            lp_q  <= sel_st;
            tmr_q <= TW'(ENTER_LAT - 1);
          end
        end
        PH_ENTER: begin
          if (tmr_q == '0) begin
            pend_q <= 1'b0;
            if (pend_q || req) begin
              ph_q  <= PH_WAKE;
              tmr_q <= wake_m1;
            end else begin
              ph_q <= PH_SLEEP;
            end
          end else begin
            pend_q <= pend_q || req;
            tmr_q  <= tmr_q - 1'b1;
          end
        end
        PH_SLEEP: begin
          if (req) begin
            ph_q  <= PH_WAKE;
            tmr_q <= wake_m1;
          end
        end
        default: begin
          if (tmr_q == '0) ph_q <= PH_ACTIVE;
          else             tmr_q <= tmr_q - 1'b1;
        end
      endcase
    end
  end

  assign is_active  = (ph_q == PH_ACTIVE);
  assign transit    = (ph_q == PH_ENTER) || (ph_q == PH_WAKE);
  assign bank_state = is_active ? ST_ACTIVE : lp_q;
endmodule

// File: rtl/bank_pwr_ctrl.sv
module bank_pwr_ctrl #(
  parameter int MAX_OUT   = 4,
  parameter int THR_W     = 12,
  parameter int ENTER_LAT = 2,
  parameter int WAKE_SB   = 2,
  parameter int WAKE_NP   = 10,
  parameter int WAKE_PD   = 50,
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             cpl_valid,
  input  logic [THR_W-1:0] idle_limit,
  input  logic [1:0]       sleep_sel,
  output logic [1:0]       bank_state,
  output logic             transit,
  output logic [CW-1:0]    inflight
);
  logic is_active;
  logic full;
  logic drained;
  logic expire;
  logic grant;

  assign req_ready = is_active && !full;
  assign grant     = req_valid && req_ready;

  bank_inflight_ctr #(.MAX_OUT(MAX_OUT)) ctr_i (
    .clk  (clk),
    .rst  (rst),
    .inc  (grant),
    .cpl  (cpl_valid),
    .cnt  (inflight),
    .zero (drained),
    .full (full)
  );

  bank_idle_timer #(.THR_W(THR_W)) idle_i (
    .clk     (clk),
    .rst     (rst),
    .active  (is_active),
    .drained (drained),
    .req     (req_valid),
    .limit   (idle_limit),
    .expire  (expire)
  );

  bank_pwr_fsm #(
    .ENTER_LAT (ENTER_LAT),
    .WAKE_SB   (WAKE_SB),
    .WAKE_NP   (WAKE_NP),
    .WAKE_PD   (WAKE_PD)
  ) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .req        (req_valid),
    .expire     (expire),
    .sleep_sel  (sleep_sel),
    .is_active  (is_active),
    .transit    (transit),
    .bank_state (bank_state)
  );
endmodule

// File: rtl/bank_pwr_ctrl_chk.sv
module bank_pwr_ctrl_chk #(
  parameter int MAX_OUT = 4,
  localparam int CW = $clog2(MAX_OUT + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          cpl_valid,
  input logic [1:0]    bank_state,
  input logic          transit,
  input logic [CW-1:0] inflight
);
  // R2
  ready_when_awake_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bank_state == 2'd0 && !transit));

  // R3
  inflight_up_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !cpl_valid) |=> (inflight == $past(inflight) + 1'b1));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (inflight == '0 && !(req_valid && req_ready)) |=> (inflight == '0));

  // R4
  busy_stays_awake_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_state == 2'd0 && !transit && inflight != '0) |=> (bank_state == 2'd0 && !transit));

  // R7
  sleep_state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_state != 2'd0) |=> (bank_state == $past(bank_state) || bank_state == 2'd0));

  // R9
  wake_not_instant_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_state != 2'd0 && !transit) |=> !req_ready);
endmodule

bind bank_pwr_ctrl bank_pwr_ctrl_chk #(.MAX_OUT(MAX_OUT)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .cpl_valid  (cpl_valid),
  .bank_state (bank_state),
  .transit    (transit),
  .inflight   (inflight)
);

// File: tb/bank_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module bank_pwr_ctrl_tb_top;
  localparam int MAXO = 4;
  localparam int THRW = 12;
  localparam int ELAT = 2;
  localparam int WSB  = 2;
  localparam int WNP  = 10;
  localparam int WPD  = 50;
  localparam int CW   = $clog2(MAXO + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            cpl_valid = 1'b0;
  logic [THRW-1:0] idle_limit = 12'd4000;
  logic [1:0]      sleep_sel = 2'd1;
  logic            req_ready;
  logic [1:0]      bank_state;
  logic            transit;
  logic [CW-1:0]   inflight;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  bank_pwr_ctrl #(
    .MAX_OUT(MAXO), .THR_W(THRW), .ENTER_LAT(ELAT),
    .WAKE_SB(WSB), .WAKE_NP(WNP), .WAKE_PD(WPD)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .cpl_valid(cpl_valid), .idle_limit(idle_limit), .sleep_sel(sleep_sel),
    .bank_state(bank_state), .transit(transit), .inflight(inflight)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 awake, 1 entering, 2 asleep, 3 waking
  int m_ph, m_lp, m_left, m_idle, m_cnt;
  bit m_pend;

  function automatic int wake_len(input int s);
    if (s == 2) return WNP;
    if (s == 3) return WPD;
    return WSB;
  endfunction

  always @(posedge clk) begin
    bit rdy, g, d, quiet, ex;
    if (rst) begin
      m_ph = 0; m_lp = 1; m_left = 0; m_idle = 0; m_cnt = 0; m_pend = 0;
    end else begin
      rdy   = (m_ph == 0) && (m_cnt < MAXO);
      g     = req_valid && rdy;
      d     = cpl_valid && (m_cnt > 0);
      quiet = (m_ph == 0) && (m_cnt == 0) && !req_valid;
      ex    = quiet && (m_idle >= int'(idle_limit));
      if (quiet) begin
        if (m_idle < (1 << THRW) - 1) m_idle++;
      end else m_idle = 0;
      m_cnt = m_cnt + int'(g) - int'(d);
      case (m_ph)
        0: if (ex) begin m_ph = 1; m_lp = (sleep_sel == 0) ? 1 : int'(sleep_sel); m_left = ELAT; end
        1: begin
             m_pend = m_pend || req_valid;
             m_left--;
             if (m_left == 0) begin
               if (m_pend) begin m_ph = 3; m_left = wake_len(m_lp); end
               else m_ph = 2;
               m_pend = 0;
             end
           end
        2: if (req_valid) begin m_ph = 3; m_left = wake_len(m_lp); end
        default: begin m_left--; if (m_left == 0) m_ph = 0; end
      endcase
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      chk(req_ready == ((m_ph == 0) && (m_cnt < MAXO)), "R2 ready vs model", req_ready, (m_ph == 0) && (m_cnt < MAXO));
      chk(int'(inflight) == m_cnt, "R3 inflight vs model", inflight, m_cnt);
      chk(int'(bank_state) == ((m_ph == 0) ? 0 : m_lp), "R7 state vs model", bank_state, (m_ph == 0) ? 0 : m_lp);
      chk(transit == ((m_ph == 1) || (m_ph == 3)), "R8 transit vs model", transit, (m_ph == 1) || (m_ph == 3));
    end
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic until_asleep(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (bank_state == 2'd0 && k < 300);
  endtask

  task automatic until_ready(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!req_ready && k < 300);
  endtask

  initial begin
    int k;
    step(3);
    rst = 1'b0;
    // R1 reset values
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(bank_state == 2'd0, "R1 state", bank_state, 0);
    chk(inflight == '0, "R1 inflight", inflight, 0);
    chk(transit == 1'b0, "R1 transit", transit, 0);

    // R2 / R3: fill, saturate, mixed, underflow
    req_valid = 1'b1; step(4);
    chk(inflight == CW'(MAXO), "R3 filled", inflight, MAXO);
    chk(req_ready == 1'b0, "R2 full blocks", req_ready, 0);
    cpl_valid = 1'b1; step(1);
    chk(inflight == CW'(3), "R3 completion", inflight, 3);
    step(1);
    chk(inflight == CW'(3), "R3 grant+completion", inflight, 3);
    req_valid = 1'b0; step(3);
    chk(inflight == '0, "R3 drained", inflight, 0);
    step(1);
    chk(inflight == '0, "R3 completion at zero", inflight, 0);

    // R6: a request restarts the idle count before measuring
    cpl_valid = 1'b0; req_valid = 1'b1; step(1);
    req_valid = 1'b0; cpl_valid = 1'b1; step(1);
    // R4 / R7 / R8: limit 5, nap
    cpl_valid = 1'b0; idle_limit = 12'd5; sleep_sel = 2'd2;
    until_asleep(k);
    chk(k == 6, "R4 cycles to sleep", k, 6);
    chk(bank_state == 2'd2, "R7 nap chosen", bank_state, 2);
    chk(transit == 1'b1, "R8 entering", transit, 1);
    step(ELAT);
    chk(transit == 1'b0, "R8 entry done", transit, 0);
    chk(bank_state == 2'd2, "R8 state held", bank_state, 2);
    step(3);

    // R9: nap wake
    req_valid = 1'b1; until_ready(k);
    chk(k == WNP + 1, "R9 nap wake", k, WNP + 1);
    step(1);
    req_valid = 1'b0; cpl_valid = 1'b1; idle_limit = '0; sleep_sel = 2'd3; step(1);
    // R5: zero limit sleeps on drain
    cpl_valid = 1'b0; until_asleep(k);
    chk(k == 1, "R5 sleep on drain", k, 1);
    chk(bank_state == 2'd3, "R7 powerdown chosen", bank_state, 3);
    step(ELAT + 2);
    req_valid = 1'b1; until_ready(k);
    chk(k == WPD + 1, "R9 powerdown wake", k, WPD + 1);
    step(1);
    req_valid = 1'b0; cpl_valid = 1'b1; sleep_sel = 2'd0; step(1);

    // R10: request during entry, select 0 maps to standby (R7)
    cpl_valid = 1'b0; until_asleep(k);
    chk(bank_state == 2'd1, "R7 select 0 standby", bank_state, 1);
    req_valid = 1'b1; until_ready(k);
    chk(k == ELAT + WSB, "R10 entry then wake", k, ELAT + WSB);
    step(1);
    req_valid = 1'b0; cpl_valid = 1'b1; idle_limit = 12'd8; sleep_sel = 2'd1; step(1);

    // R6: idle run interrupted by a request, count restarts
    cpl_valid = 1'b0; step(4);
    chk(bank_state == 2'd0, "R6 still awake", bank_state, 0);
    req_valid = 1'b1; step(1);
    req_valid = 1'b0; cpl_valid = 1'b1; step(1);
    cpl_valid = 1'b0; until_asleep(k);
    chk(k == 9, "R6 full idle period after request", k, 9);
    chk(bank_state == 2'd1, "R7 standby chosen", bank_state, 1);
    step(ELAT + 1);
    req_valid = 1'b1; until_ready(k);
    chk(k == WSB + 1, "R9 standby wake", k, WSB + 1);
    req_valid = 1'b0;
    step(2);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule